// File: doc/BRIEF.md
# Four-Way Victim Way Selector

This block picks the way that a four-way set-associative cache fills when a lookup misses. The cache presents the four valid bits of the indexed set. The block answers in the same cycle with a two-bit way index. An invalid way is always taken ahead of a valid one. When every candidate way is already valid, a two-bit rotating counter chooses the victim. The counter advances only on the cycle the cache asserts its allocate strobe.

A half-lock input protects ways 0 and 1 from replacement. While it is high, only ways 2 and 3 can be chosen. In that mode the top bit of the counter picks between ways 2 and 3 and toggles after each use. The mode may be flipped at any cycle. Changing it neither clears nor reloads the counter, so allocations already made stay where they are.

Top module: `way_victim_sel`

## Requirements
- R1: After reset the rotating counter is 0, so a normal-mode set with all four ways valid selects way 0.
- R2: In normal mode (half_lock_i = 0), if any valid bit is 0, way_o is the lowest-numbered way whose valid bit is 0.
- R3: In normal mode with all four valid bits set, way_o equals the counter. An allocate in that state adds 1 to the counter, wrapping from 3 to 0.
- R4: In half-lock mode, way_o is 2 if valid bit 2 is 0; otherwise it is 3 if valid bit 3 is 0. Valid bits 0 and 1 are ignored.
- R5: In half-lock mode with valid bits 2 and 3 both set, way_o is 2 when counter bit 1 is 0 and 3 when it is 1. An allocate in that state inverts counter bit 1 and leaves counter bit 0 unchanged.
- R6: While half_lock_i is 1, way_o is never 0 or 1.
- R7: The counter changes only on a clock edge where alloc_i is 1 and every candidate way is valid. An allocate that fills an invalid way, and any cycle without alloc_i, leave it unchanged.
- R8: way_o depends combinationally on valid_i, half_lock_i and the current counter, so it is valid in the same cycle that alloc_i is asserted.
- R9: Changing half_lock_i does not reset or alter the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the counter |
| alloc_i | input | 1 | Allocate strobe for the current set |
| half_lock_i | input | 1 | 1 confines replacement to ways 2 and 3 |
| valid_i | input | 4 | Valid bits of the indexed set, bit n for way n |
| way_o | output | 2 | Selected way index |

## Verification
The bench runs the counter through a full wrap from 3 to 0. A design that dropped the carry, or never wrapped, would return the wrong way on the fifth tie. It alternates half-lock ties across a counter value with the low bit set, and then returns to normal mode. A design that incremented the whole counter, or cleared it when the mode changed, would report a normal-mode way other than 1. It allocates into invalid ways, and holds alloc_i low for several idle cycles. A counter that moved on those cycles would show up as a shifted tie choice. Half-lock cases with ways 0 and 1 invalid catch a selector that still honours the lowest invalid way across all four ways.

// File: rtl/way_victim_sel.sv
module way_victim_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alloc_i,
  input  logic       half_lock_i,
  input  logic [3:0] valid_i,
  output logic [1:0] way_o
);

  logic [1:0] rr_q;
  logic [1:0] rr_d;
  logic       tie;
  logic [1:0] norm_way;
  logic [1:0] half_way;

  assign tie = half_lock_i ? &valid_i[3:2] : &valid_i;

  always_comb begin
    if      (!valid_i[0]) norm_way = 2'd0;
    else if (!valid_i[1]) norm_way = 2'd1;
    else if (!valid_i[2]) norm_way = 2'd2;
    else if (!valid_i[3]) norm_way = 2'd3;
    else                  norm_way = rr_q;
  end

  always_comb begin
    if      (!valid_i[2]) half_way = 2'd2;
    else if (!valid_i[3]) half_way = 2'd3;
    else                  half_way = {1'b1, rr_q[1]};
  end

  assign way_o = half_lock_i ? half_way : norm_way;
  assign rr_d  = half_lock_i ? {~rr_q[1], rr_q[0]} : rr_q + 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n)             rr_q <= 2'd0;
    else if (alloc_i && tie) rr_q <= rr_d;
  end

  p_lowest_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_lock_i && !(&valid_i)) |-> !valid_i[way_o]);

  p_norm_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !half_lock_i && &valid_i) |=> (rr_q == $past(rr_q) + 2'd1));

  p_half_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && half_lock_i && &valid_i[3:2]) |=>
      (rr_q[1] != $past(rr_q[1]) && rr_q[0] == $past(rr_q[0])));

  p_upper_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    half_lock_i |-> way_o[1]);

  p_counter_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_i && (half_lock_i ? &valid_i[3:2] : &valid_i)) |=> $stable(rr_q));

endmodule

// File: tb/sim_way_victim_sel.sv
module sim_way_victim_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_i = 1'b0;
  logic       half_lock_i = 1'b0;
  logic [3:0] valid_i = 4'h0;
  logic [1:0] way_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  way_victim_sel u0 (.clk(clk), .rst_n(rst_n), .alloc_i(alloc_i),
                     .half_lock_i(half_lock_i), .valid_i(valid_i), .way_o(way_o));

  always #2 clk = ~clk;

  // {half, valid[3:0], expected way} with counter at 0 and no allocate
  localparam logic [6:0] VEC [13] = '{
    {1'b0, 4'b0000, 2'd0}, {1'b0, 4'b0001, 2'd1}, {1'b0, 4'b0011, 2'd2},
    {1'b0, 4'b0111, 2'd3}, {1'b0, 4'b1010, 2'd0}, {1'b0, 4'b1101, 2'd1},
    {1'b0, 4'b1011, 2'd2}, {1'b0, 4'b0110, 2'd0}, {1'b1, 4'b0000, 2'd2},
    {1'b1, 4'b0011, 2'd2}, {1'b1, 4'b0111, 2'd3}, {1'b1, 4'b1011, 2'd2},
    {1'b1, 4'b1111, 2'd2}};

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: way_o=%0d expected %0d", req, got, exp);
    end
  endtask

  // drive after a falling edge, check 1 ns later, then let the rising edge act
  task automatic step(input logic h, input logic [3:0] v, input logic a,
                      input logic [1:0] exp, input string req);
    @(negedge clk);
    half_lock_i = h; valid_i = v; alloc_i = a;
    #1 chk(req, way_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 4'hF, 1'b0, 2'd0, "R1");
    foreach (VEC[i])
      step(VEC[i][6], VEC[i][5:2], 1'b0, VEC[i][1:0], VEC[i][6] ? "R4/R6" : "R2");
    // R3: counter walk and wrap; R8: way valid with strobe
    step(1'b0, 4'hF, 1'b1, 2'd0, "R3");
    step(1'b0, 4'hF, 1'b1, 2'd1, "R3");
    step(1'b0, 4'hF, 1'b1, 2'd2, "R3");
    step(1'b0, 4'hF, 1'b1, 2'd3, "R8");
    step(1'b0, 4'hF, 1'b0, 2'd0, "R3 wrap");
    // R7: invalid-way fill does not advance
    step(1'b0, 4'b1011, 1'b1, 2'd2, "R2");
    step(1'b0, 4'hF, 1'b1, 2'd0, "R7");
    // counter now 1; half-lock ties
    step(1'b1, 4'hF, 1'b1, 2'd2, "R5");
    step(1'b1, 4'hF, 1'b1, 2'd3, "R5");
    step(1'b1, 4'hF, 1'b0, 2'd2, "R5");
    // R9: mode change keeps counter (low bit preserved => 1)
    step(1'b0, 4'hF, 1'b0, 2'd1, "R9");
    repeat (4) step(1'b0, 4'hF, 1'b0, 2'd1, "R7 idle");
    step(1'b1, 4'b1011, 1'b1, 2'd2, "R4");
    step(1'b1, 4'b0000, 1'b1, 2'd2, "R6");
    step(1'b0, 4'hF, 1'b0, 2'd1, "R7");
    // reset mid-run returns counter to 0
    @(negedge clk); rst_n = 1'b0; alloc_i = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 4'hF, 1'b0, 2'd0, "R1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule